// File: doc/BRIEF.md
# Flash Page Program Sequencer

This block sequences the programming of an embedded flash array from a small set of mode-control bits, and includes a behavioural model of the array. Software first sets the program-mode bit. The first data write after that is the interlock write. It fixes the target page and starts filling a four-word page buffer. Further data writes to the same page add words to the buffer. Software then sets the high-voltage bit, which starts a timed internal operation. When the operation ends, a done flag rises and a pass flag reports the result.

The array model starts fully erased, and a program operation can only clear bits. Each block of pages has a lock input. Each aligned 64-bit segment keeps a record of whether it has already been programmed, since its check bits are written once. Software clears the high-voltage bit after done. It can then start another page in the same program session, or clear program mode to end the session. A 32-bit read port gives direct access to the array contents.

Top module: `flash_prog_seq`

## Requirements
- R1: A successful operation sets each written word to the old word AND the buffered data. A bit that is 0 in the array never returns to 1.
- R2: `lock_i[b]` = 1 locks block b. Block b is the set of pages whose index, divided by NUM_PAGES/NUM_BLOCKS, equals b. An operation on a page in a locked block ends with done high and pass low, and the array is left unchanged.
- R3: A page holds four 32-bit words. The page index is `bus_addr_i[ADDR_W-1:4]` and `bus_addr_i[3:2]` selects the word. One operation programs every written word of the page. Unwritten words stay as they were, because the buffer holds 0xFFFF_FFFF for them.
- R4: Segment s of a page covers words 2s and 2s+1. A successful operation marks every segment it writes to. A later operation that writes either word of a marked segment fails with pass low, and the array is left unchanged.
- R5: In program mode, the first data write is the interlock write and sets the page. A doubleword write (`bus_dw_i`=1) needs `bus_addr_i[2]`=0: data [31:0] goes to the even word and data [63:32] goes to the odd word. A misaligned doubleword write is ignored and sets `seq_err_o`.
- R6: `done_o` rises exactly PROG_CYCLES clock edges after the edge that accepts the high-voltage set with data buffered. Until then `done_o` stays low, and data writes and control writes are ignored without any error.
- R7: The high-voltage bit can only be set while program mode is already on. Otherwise it stays 0. A clean operation ends with `pass_o`=1.
- R8: Clearing the high-voltage bit clears `done_o` on the same edge and empties the buffer. The next data write becomes a new interlock write, which may target another page.
- R9: Clearing program mode before the high-voltage bit was ever set discards the buffer. The array is left unchanged and no segment is marked.
- R10: A data write outside program mode, or to a page other than the interlock page, is ignored and sets `seq_err_o`. The flag stays set until program mode is next entered.
- R11: Setting the high-voltage bit with no interlock write captured raises `done_o` on that same edge, with `pass_o` low.
- R12: After reset the array reads all ones, and `pgm_o`, `ehv_o`, `done_o`, `pass_o` and `seq_err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the mode-control bits |
| cfg_pgm_i | input | 1 | New value of the program-mode bit |
| cfg_ehv_i | input | 1 | New value of the high-voltage start bit |
| pgm_o | output | 1 | Program mode is active |
| ehv_o | output | 1 | High-voltage bit |
| done_o | output | 1 | Operation finished |
| pass_o | output | 1 | Result of the last finished operation |
| seq_err_o | output | 1 | Sticky sequence error |
| lock_i | input | NUM_BLOCKS (4) | Lock for each block |
| bus_we_i | input | 1 | Data write strobe |
| bus_dw_i | input | 1 | Marks a 64-bit write |
| bus_addr_i | input | ADDR_W (8) | Byte address of a data write |
| bus_wdata_i | input | 64 | Write data |
| rd_addr_i | input | ADDR_W-2 (6) | Word address for array reads |
| rd_data_o | output | 32 | Array word at `rd_addr_i` (combinational) |

## Verification
Control writes and data writes take effect on the clock edge that samples them, and every flag can be seen at the following falling edge. The exception is `done_o` for a real operation: it rises PROG_CYCLES edges after the accepting edge. The bench checks that it is still low at the falling edge one cycle before, and high at the next one. A start with no data buffered shows `done_o` right after the accepting edge. Array contents are read combinationally, one nanosecond after a falling edge, once the operation and its clean-up writes are over.

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam int WORD_W     = 32;
  localparam int PAGE_WORDS = 4;
  localparam int SEGS       = PAGE_WORDS / 2;
  typedef logic [PAGE_WORDS-1:0][WORD_W-1:0] page_t;
endpackage

// File: rtl/fps_page_buf.sv
module fps_page_buf
  import fps_pkg::*;
#(
  parameter int PG_W = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  wr_i,
  input  logic                  dw_i,
  input  logic [PG_W-1:0]       page_i,
  input  logic [1:0]            sel_i,
  input  logic [63:0]           wdata_i,
  output logic                  valid_o,
  output logic [PG_W-1:0]       page_o,
  output logic [PAGE_WORDS-1:0] mask_o,
  output page_t                 data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      page_o  <= '0;
      mask_o  <= '0;
      data_o  <= '1;
    end else if (clr_i) begin
      valid_o <= 1'b0;
      mask_o  <= '0;
      data_o  <= '1;
    end else if (wr_i) begin
      valid_o <= 1'b1;
      page_o  <= page_i;
      if (dw_i) begin
        data_o[{sel_i[1], 1'b0}] <= wdata_i[31:0];
        data_o[{sel_i[1], 1'b1}] <= wdata_i[63:32];
        mask_o[{sel_i[1], 1'b0}] <= 1'b1;
        mask_o[{sel_i[1], 1'b1}] <= 1'b1;
      end else begin
        data_o[sel_i] <= wdata_i[31:0];
        mask_o[sel_i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fps_timer.sv
module fps_timer #(
  parameter int CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic fin_o
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign fin_o = busy_o && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      cnt_q  <= CNT_W'(CYCLES - 1);
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/fps_array.sv
module fps_array
  import fps_pkg::*;
#(
  parameter int NUM_PAGES  = 16,
  parameter int NUM_BLOCKS = 4,
  parameter int PG_W       = 4,
  parameter int WA_W       = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  commit_i,
  input  logic [PG_W-1:0]       page_i,
  input  logic [PAGE_WORDS-1:0] mask_i,
  input  page_t                 data_i,
  input  logic [NUM_BLOCKS-1:0] lock_i,
  input  logic [WA_W-1:0]       rd_addr_i,
  output logic                  ok_o,
  output logic [WORD_W-1:0]     rd_data_o
);
  localparam int BLK_W  = $clog2(NUM_BLOCKS);
  localparam int BLK_SH = $clog2(NUM_PAGES / NUM_BLOCKS);

  page_t            mem_q [NUM_PAGES];
  logic [SEGS-1:0]  seg_q [NUM_PAGES];
  logic [SEGS-1:0]  touch;
  logic [PG_W-1:0]  blk_idx;

  for (genvar s = 0; s < SEGS; s++) begin : g_touch
    assign touch[s] = mask_i[2*s] | mask_i[2*s+1];
  end

  assign blk_idx   = page_i >> BLK_SH;
  assign ok_o      = !lock_i[blk_idx[BLK_W-1:0]] && ((touch & seg_q[page_i]) == '0);
  assign rd_data_o = mem_q[rd_addr_i[WA_W-1:2]][rd_addr_i[1:0]];

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[p] <= '1;
        seg_q[p] <= '0;
      end else if (commit_i && ok_o && (page_i == PG_W'(p))) begin
        for (int w = 0; w < PAGE_WORDS; w++) begin
          if (mask_i[w]) mem_q[p][w] <= mem_q[p][w] & data_i[w];
        end
        seg_q[p] <= seg_q[p] | touch;
      end
    end
  end
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import fps_pkg::*;
#(
  parameter int NUM_PAGES   = 16,
  parameter int NUM_BLOCKS  = 4,
  parameter int PROG_CYCLES = 8,
  parameter int ADDR_W      = $clog2(NUM_PAGES) + 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic                  cfg_pgm_i,
  input  logic                  cfg_ehv_i,
  output logic                  pgm_o,
  output logic                  ehv_o,
  output logic                  done_o,
  output logic                  pass_o,
  output logic                  seq_err_o,
  input  logic [NUM_BLOCKS-1:0] lock_i,
  input  logic                  bus_we_i,
  input  logic                  bus_dw_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  input  logic [63:0]           bus_wdata_i,
  input  logic [ADDR_W-3:0]     rd_addr_i,
  output logic [WORD_W-1:0]     rd_data_o
);
  localparam int PG_W = ADDR_W - 4;
  localparam int WA_W = ADDR_W - 2;

  logic                  busy, fin, ok;
  logic                  buf_valid;
  logic [PG_W-1:0]       buf_page;
  logic [PAGE_WORDS-1:0] buf_mask;
  page_t                 buf_data;

  logic cfg_acc, ehv_next, start, start_real, start_nil, pgm_rise, buf_clr;
  logic misal, page_hit, wr_ok, err_set;

  assign cfg_acc    = cfg_we_i && !busy;
  assign ehv_next   = cfg_ehv_i && cfg_pgm_i && pgm_o;
  assign start      = cfg_acc && ehv_next && !ehv_o;
  assign start_real = start && buf_valid;
  assign start_nil  = start && !buf_valid;
  assign pgm_rise   = cfg_acc && cfg_pgm_i && !pgm_o;
  // leaving either mode drops the buffered page
  assign buf_clr    = cfg_acc && ((pgm_o != cfg_pgm_i) || (ehv_o && !ehv_next));

  assign misal    = bus_dw_i && bus_addr_i[2];
  assign page_hit = !buf_valid || (bus_addr_i[ADDR_W-1:4] == buf_page);
  assign wr_ok    = bus_we_i && pgm_o && !ehv_o && !misal && page_hit;
  assign err_set  = bus_we_i && (!pgm_o || (!ehv_o && (misal || !page_hit)));

  fps_page_buf #(.PG_W(PG_W)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (buf_clr),
    .wr_i    (wr_ok),
    .dw_i    (bus_dw_i),
    .page_i  (bus_addr_i[ADDR_W-1:4]),
    .sel_i   (bus_addr_i[3:2]),
    .wdata_i (bus_wdata_i),
    .valid_o (buf_valid),
    .page_o  (buf_page),
    .mask_o  (buf_mask),
    .data_o  (buf_data)
  );

  fps_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_real),
    .busy_o  (busy),
    .fin_o   (fin)
  );

  fps_array #(
    .NUM_PAGES  (NUM_PAGES),
    .NUM_BLOCKS (NUM_BLOCKS),
    .PG_W       (PG_W),
    .WA_W       (WA_W)
  ) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .commit_i  (fin),
    .page_i    (buf_page),
    .mask_i    (buf_mask),
    .data_i    (buf_data),
    .lock_i    (lock_i),
    .rd_addr_i (rd_addr_i),
    .ok_o      (ok),
    .rd_data_o (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pgm_o     <= 1'b0;
      ehv_o     <= 1'b0;
      done_o    <= 1'b0;
      pass_o    <= 1'b0;
      seq_err_o <= 1'b0;
    end else begin
      if (cfg_acc) begin
        pgm_o <= cfg_pgm_i;
        ehv_o <= ehv_next;
        if (ehv_o && !ehv_next) done_o <= 1'b0;
      end
      if (start_nil) begin
        done_o <= 1'b1;
        pass_o <= 1'b0;
      end
      if (start_real) begin
        done_o <= 1'b0;
        pass_o <= 1'b0;
      end
      if (fin) begin
        done_o <= 1'b1;
        pass_o <= ok;
      end
      if (err_set)       seq_err_o <= 1'b1;
      else if (pgm_rise) seq_err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
  parameter int WA_W = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cfg_we_i,
  input logic            cfg_pgm_i,
  input logic            pgm_o,
  input logic            ehv_o,
  input logic            done_o,
  input logic            pass_o,
  input logic            seq_err_o,
  input logic [WA_W-1:0] rd_addr_i,
  input logic [31:0]     rd_data_o
);
  // R7: the high-voltage bit only lives inside program mode
  a_r7_ehv_needs_pgm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ehv_o |-> pgm_o);

  // R6: done only reported while an operation is open
  a_r6_done_in_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ehv_o);

  a_r8_done_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ehv_o) |-> !done_o);

  a_r11_nil_fails: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ehv_o) && done_o) |-> !pass_o);

  a_r1_bits_only_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(rd_addr_i) |-> ((rd_data_o & ~$past(rd_data_o)) == '0));

  a_r6_array_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ehv_o && !done_o && $stable(rd_addr_i)) |-> $stable(rd_data_o));

  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_err_o && !(cfg_we_i && cfg_pgm_i && !pgm_o)) |=> seq_err_o);
endmodule

bind flash_prog_seq fps_checker #(.WA_W(WA_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg_we_i  (cfg_we_i),
  .cfg_pgm_i (cfg_pgm_i),
  .pgm_o     (pgm_o),
  .ehv_o     (ehv_o),
  .done_o    (done_o),
  .pass_o    (pass_o),
  .seq_err_o (seq_err_o),
  .rd_addr_i (rd_addr_i),
  .rd_data_o (rd_data_o)
);

// File: tb/test_flash_prog_seq.sv
`timescale 1ns/1ps
module test_flash_prog_seq;
  localparam int P = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0, cfg_pgm_i = 1'b0, cfg_ehv_i = 1'b0;
  logic        pgm_o, ehv_o, done_o, pass_o, seq_err_o;
  logic [3:0]  lock_i = '0;
  logic        bus_we_i = 1'b0, bus_dw_i = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic [63:0] bus_wdata_i = '0;
  logic [5:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;

  always #2.5 clk_i = ~clk_i;

  flash_prog_seq #(.NUM_PAGES(16), .NUM_BLOCKS(4), .PROG_CYCLES(P)) i_flash_prog_seq (.*);

  int nvec = 0, nbad = 0;
  bit ended = 0;
  logic [31:0] mdl [64];

  typedef struct packed {
    logic [3:0]  lock;
    logic [7:0]  addr;
    logic        dw;
    logic [63:0] data;
    logic        pass;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{4'b0000, 8'h00, 1'b0, 64'h0000_0000_A5A5_0F0F, 1'b1},
    '{4'b0000, 8'h08, 1'b1, 64'h1234_5678_9ABC_DEF0, 1'b1},
    '{4'b0000, 8'h04, 1'b0, 64'h0000_0000_0000_0000, 1'b0},
    '{4'b0010, 8'h40, 1'b1, 64'h0000_0000_0000_0000, 1'b0},
    '{4'b0000, 8'h40, 1'b1, 64'hFF00_FF00_00FF_00FF, 1'b1},
    '{4'b0001, 8'hF8, 1'b1, 64'hCAFE_0001_BEEF_0002, 1'b1},
    '{4'b0000, 8'h44, 1'b0, 64'h0000_0000_0000_0000, 1'b0},
    '{4'b1000, 8'hC4, 1'b0, 64'h0000_0000_1111_1111, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic pgm, input logic ehv);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_pgm_i = pgm; cfg_ehv_i = ehv;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic dw, input logic [63:0] d);
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_addr_i = a; bus_dw_i = dw; bus_wdata_i = d;
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input int w);
    @(negedge clk_i);
    rd_addr_i = 6'(w);
    #1 chk(tag, rd_data_o, mdl[w]);
  endtask

  // R6 / R7: start, done timing, result, then drop the high-voltage bit
  task automatic run_op(input logic exp_pass, input string tag);
    cfg(1'b1, 1'b1);
    repeat (P - 1) @(negedge clk_i);
    chk("R6 done low before end", 32'(done_o), 32'd0);
    @(negedge clk_i);
    chk("R6 done at end", 32'(done_o), 32'd1);
    chk(tag, 32'(pass_o), 32'(exp_pass));
    cfg(1'b1, 1'b0);
    chk("R8 done cleared", 32'(done_o), 32'd0);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    nvec++; nbad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) mdl[i] = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R12 reset state
    chk("R12 pgm", 32'(pgm_o), 0);
    chk("R12 ehv", 32'(ehv_o), 0);
    chk("R12 done", 32'(done_o), 0);
    chk("R12 pass", 32'(pass_o), 0);
    chk("R12 err", 32'(seq_err_o), 0);
    rd_chk("R12 erased", 5);

    // table: R1 R2 R4 R7
    for (int v = 0; v < 8; v++) begin
      lock_i = VEC[v].lock;
      cfg(1'b1, 1'b0);
      bus_wr(VEC[v].addr, VEC[v].dw, VEC[v].data);
      run_op(VEC[v].pass, "R7/R2/R4 pass flag");
      cfg(1'b0, 1'b0);
      if (VEC[v].pass) begin
        mdl[VEC[v].addr >> 2] &= VEC[v].data[31:0];
        if (VEC[v].dw) mdl[(VEC[v].addr >> 2) + 1] &= VEC[v].data[63:32];
      end
      rd_chk("R1 word", VEC[v].addr >> 2);
      if (VEC[v].dw) rd_chk("R1 upper word", (VEC[v].addr >> 2) + 1);
    end
    lock_i = '0;

    // R3 several words of one page, word 0 untouched
    cfg(1'b1, 1'b0);
    bus_wr(8'h24, 1'b0, 64'h0000_0000_DEAD_BEEF);
    bus_wr(8'h28, 1'b0, 64'h0000_0000_1111_0000);
    bus_wr(8'h2C, 1'b0, 64'h0000_0000_0000_2222);
    run_op(1'b1, "R3 page pass");
    mdl[9] &= 32'hDEAD_BEEF; mdl[10] &= 32'h1111_0000; mdl[11] &= 32'h0000_2222;
    for (int w = 8; w < 12; w++) rd_chk("R3 page word", w);

    // R8 new interlock on another page within one session
    bus_wr(8'h80, 1'b1, 64'h0F0F_0F0F_F0F0_F0F0);
    run_op(1'b1, "R8 second page pass");
    mdl[32] &= 32'hF0F0_F0F0; mdl[33] &= 32'h0F0F_0F0F;
    rd_chk("R8 second page lo", 32);
    rd_chk("R8 second page hi", 33);
    cfg(1'b0, 1'b0);

    // R10 write to a foreign page
    cfg(1'b1, 1'b0);
    bus_wr(8'h30, 1'b1, 64'h0000_FFFF_FFFF_0000);
    bus_wr(8'h50, 1'b0, 64'h0);
    chk("R10 foreign page err", 32'(seq_err_o), 1);
    run_op(1'b1, "R10 pass after foreign write");
    mdl[12] &= 32'hFFFF_0000; mdl[13] &= 32'h0000_FFFF;
    rd_chk("R10 interlock page", 12);
    rd_chk("R10 foreign word untouched", 20);
    cfg(1'b0, 1'b0);
    chk("R10 err sticky", 32'(seq_err_o), 1);
    cfg(1'b1, 1'b0);
    chk("R10 err cleared on entry", 32'(seq_err_o), 0);
    cfg(1'b0, 1'b0);
    bus_wr(8'h60, 1'b0, 64'h0);
    chk("R10 write outside mode err", 32'(seq_err_o), 1);
    rd_chk("R10 outside mode untouched", 24);

    // R5 misaligned doubleword, then R11 start with nothing buffered
    cfg(1'b1, 1'b0);
    bus_wr(8'h64, 1'b1, 64'h0);
    chk("R5 misaligned err", 32'(seq_err_o), 1);
    cfg(1'b1, 1'b1);
    chk("R11 done at once", 32'(done_o), 1);
    chk("R11 pass low", 32'(pass_o), 0);
    cfg(1'b1, 1'b0);
    rd_chk("R5 misaligned lo untouched", 25);
    rd_chk("R5 misaligned hi untouched", 26);

    // R9 abandon buffered data
    bus_wr(8'h70, 1'b0, 64'h0);
    cfg(1'b0, 1'b0);
    rd_chk("R9 abandoned untouched", 28);
    cfg(1'b1, 1'b0);
    bus_wr(8'h70, 1'b0, 64'h0000_0000_1234_5678);
    // R6 writes during the operation are ignored
    cfg(1'b1, 1'b1);
    bus_wr(8'h78, 1'b0, 64'h0);
    repeat (P - 3) @(negedge clk_i);
    chk("R6 done low while busy", 32'(done_o), 0);
    @(negedge clk_i);
    chk("R6 done after busy write", 32'(done_o), 1);
    chk("R9 segment free after abandon", 32'(pass_o), 1);
    chk("R6 busy write no err", 32'(seq_err_o), 0);
    cfg(1'b1, 1'b0);
    cfg(1'b0, 1'b0);
    mdl[28] &= 32'h1234_5678;
    rd_chk("R9 programmed", 28);
    rd_chk("R6 busy write untouched", 30);

    finish_run();
  end
endmodule